// File: doc/BRIEF.md
# Serial Scan Self-Test Controller

This block runs a complete logic self-test on a circuit that has one serial scan chain. A one-cycle pulse on `start_i` launches a run. First, a fixed seed pattern is shifted into the chain through its serial input. The same bits also fill the pattern generator. After that, the generator drives the chain input. Each test pattern is a full chain-length shift followed by one functional capture clock. The next pattern's shift also unloads the previous response. A single-input signature register compresses every bit leaving the chain. A final unload pass empties the last response. The finished signature is then compared on chip with a golden value.

The pattern count, chain length, seed, generator taps, signature polynomial and golden signature are all elaboration parameters. A small example chain circuit is included so the controller is complete on its own. The verdict appears on `pass_o`, which is meaningful only while `done_o` is high. The raw signature is also available on `sig_o`.

Top module: `scan_selftest_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `pass_o` are 0 and `sig_o` is all zeros.
- R2: A `start_i` pulse accepted while idle or done makes `busy_o` 1 and `done_o` 0 from the next cycle on.
- R3: The first CHAIN_LEN cycles of a run form the seed phase. Each cycle shifts one SEED bit into the chain, most significant bit first. Each bit also enters the low end of the generator, so the generator ends holding the low LFSR_W bits of SEED. The signature register is held at zero during this phase.
- R4: Each pattern shifts CHAIN_LEN bits into the chain, taken from the generator's top bit. On every shift the generator moves left and takes in the XOR of its bits selected by LFSR_TAPS. One capture clock then follows. On that clock, chain bit i becomes q[i-1] XOR (q[i] AND q[i+1]), with indices wrapping around.
- R5: The chain shifts toward its high end and its top bit is the scan output. On every shift after the seed phase, including the final CHAIN_LEN unload shifts that feed zeros in, the signature is updated. It moves left, takes the scan output in at bit 0, and XORs in SIG_POLY when its old top bit was 1.
- R6: `done_o` rises exactly CHAIN_LEN*(PATTERNS+2)+PATTERNS cycles after the edge that accepted `start_i`.
- R7: While done and with no new start, `done_o` stays 1 and `sig_o` holds its value.
- R8: `pass_o` equals 1 exactly when `done_o` is 1 and `sig_o` equals GOLDEN. It is 0 at all other times.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored. The run's timing and signature are unchanged.
- R10: Each run has exactly PATTERNS capture clocks, each one cycle long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run request, sampled each rising edge |
| busy_o | output | 1 | Self-test run in progress |
| done_o | output | 1 | Run finished; verdict valid |
| pass_o | output | 1 | Signature matched golden value (valid with done) |
| sig_o | output | SIG_W | Current signature register contents |

## Verification
The bench computes the expected signature with its own bit-level model and uses it as the golden value. A design that sends the seed bits in the wrong order, absorbs the seed phase, skips the zero-fill unload pass or misplaces the capture clock therefore ends with a different signature and reports fail. Spurious start pulses are placed early in a run, in the middle of a run and on the run's very last edge. A controller that restarts would change both the completion cycle and the signature. A copy built with a deliberately wrong golden value must report fail while showing the same signature. A reset in the middle of a run must return the block to a clean state from which the next run is bit-exact. A second instance with a short chain and a narrow generator catches off-by-one errors in the counters and the seed indexing.

// File: rtl/scan_bist_pkg.sv
package scan_bist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_SHIFT,
    ST_CAPT,
    ST_UNLOAD,
    ST_DONE
  } bist_state_e;
endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic step_en,
  input  logic din,
  output logic dout
);
  logic [W-1:0] q;

  function automatic logic [W-1:0] lfsr_advance(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= {q[W-2:0], din};
    else if (step_en) q <= lfsr_advance(q);
  end

  assign dout = q[W-1];
endmodule

// File: rtl/bist_sisr.sv
module bist_sisr #(
  parameter int           W    = 8,
  parameter logic [W-1:0] POLY = 8'h1D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         absorb,
  input  logic         din,
  output logic [W-1:0] sig
);
  function automatic logic [W-1:0] sisr_step(input logic [W-1:0] s, input logic b);
    return {s[W-2:0], 1'b0} ^ (s[W-1] ? POLY : '0) ^ {{(W-1){1'b0}}, b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sig <= '0;
    else if (clear)  sig <= '0;
    else if (absorb) sig <= sisr_step(sig, din);
  end
endmodule

// File: rtl/bist_scan_cut.sv
module bist_scan_cut #(
  parameter int L = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic capture_en,
  input  logic scan_in,
  output logic scan_out
);
  logic [L-1:0] q;

  function automatic logic [L-1:0] cut_capture(input logic [L-1:0] s);
    return {s[L-2:0], s[L-1]} ^ (s & {s[0], s[L-1:1]});
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (shift_en)   q <= {q[L-2:0], scan_in};
    else if (capture_en) q <= cut_capture(q);
  end

  assign scan_out = q[L-1];
endmodule

// File: rtl/scan_selftest_ctrl.sv
module scan_selftest_ctrl #(
  parameter int                   CHAIN_LEN = 8,
  parameter int                   PATTERNS  = 6,
  parameter int                   LFSR_W    = 8,
  parameter logic [LFSR_W-1:0]    LFSR_TAPS = 8'hB8,
  parameter int                   SIG_W     = 8,
  parameter logic [SIG_W-1:0]     SIG_POLY  = 8'h1D,
  parameter logic [CHAIN_LEN-1:0] SEED      = 8'hA5,
  parameter logic [SIG_W-1:0]     GOLDEN    = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic [SIG_W-1:0] sig_o
);
  import scan_bist_pkg::*;

  localparam int CNT_W = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1;
  localparam int PAT_W = $clog2(PATTERNS + 1);

  bist_state_e state;
  logic [CNT_W-1:0] cnt;
  logic [PAT_W-1:0] pat;

  // named internal events
  logic in_seed, in_shift, in_capt, in_unload;
  logic chain_shift, last_slot, run_last_evt, start_accept;
  logic seed_bit, lfsr_bit, scan_in, scan_out;
  logic [CNT_W-1:0] seed_idx;

  assign in_seed      = (state == ST_SEED);
  assign in_shift     = (state == ST_SHIFT);
  assign in_capt      = (state == ST_CAPT);
  assign in_unload    = (state == ST_UNLOAD);
  assign chain_shift  = in_seed | in_shift | in_unload;
  assign last_slot    = (cnt == CNT_W'(CHAIN_LEN - 1));
  assign run_last_evt = in_unload & last_slot;
  assign start_accept = start_i & ((state == ST_IDLE) | (state == ST_DONE));
  assign seed_idx     = CNT_W'(CHAIN_LEN - 1) - cnt;

  always_comb begin
    seed_bit = 1'b0;
    for (int i = 0; i < CHAIN_LEN; i++)
      if (seed_idx == CNT_W'(i)) seed_bit = SEED[i];
  end

  always_comb begin
    if (in_seed)       scan_in = seed_bit;
    else if (in_shift) scan_in = lfsr_bit;
    else               scan_in = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pat   <= '0;
    end else if (start_accept) begin
      state <= ST_SEED;
      cnt   <= '0;
      pat   <= '0;
    end else begin
      case (state)
        ST_SEED, ST_SHIFT, ST_UNLOAD: begin
          cnt <= last_slot ? '0 : cnt + CNT_W'(1);
          if (last_slot) begin
            if (in_unload) state <= ST_DONE;
            else           state <= in_seed ? ST_SHIFT : ST_CAPT;
          end
        end
        ST_CAPT: begin
          pat   <= pat + PAT_W'(1);
          state <= (pat == PAT_W'(PATTERNS - 1)) ? ST_UNLOAD : ST_SHIFT;
        end
        default: ;
      endcase
    end
  end

  bist_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load_en(in_seed), .step_en(in_shift),
    .din(scan_in), .dout(lfsr_bit)
  );

  bist_scan_cut #(.L(CHAIN_LEN)) u_cut (
    .clk(clk), .rst_n(rst_n), .shift_en(chain_shift), .capture_en(in_capt),
    .scan_in(scan_in), .scan_out(scan_out)
  );

  bist_sisr #(.W(SIG_W), .POLY(SIG_POLY)) u_sisr (
    .clk(clk), .rst_n(rst_n), .clear(in_seed), .absorb(in_shift | in_unload),
    .din(scan_out), .sig(sig_o)
  );

  assign busy_o = (state != ST_IDLE) && (state != ST_DONE);
  assign done_o = (state == ST_DONE);
  assign pass_o = done_o && (sig_o == GOLDEN);
endmodule

// File: rtl/scan_selftest_chk.sv
module scan_selftest_chk #(
  parameter int CHAIN_LEN = 8,
  parameter int PATTERNS  = 6,
  parameter int SIG_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             pass,
  input logic [SIG_W-1:0] sig,
  input logic             shift_evt,
  input logic             capture_evt,
  input logic             run_last_evt
);
  logic [15:0] cap_cnt, shf_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_cnt <= '0;
      shf_cnt <= '0;
    end else if (start && !busy) begin
      cap_cnt <= '0;
      shf_cnt <= '0;
    end else begin
      if (capture_evt) cap_cnt <= cap_cnt + 16'd1;
      if (shift_evt)   shf_cnt <= shf_cnt + 16'd1;
    end
  end

  a_r8_pass_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);
  a_r2_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done);
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !run_last_evt |=> busy);
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(sig));
  a_r10_capture_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> cap_cnt == 16'(PATTERNS));
  a_r10_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> !capture_evt);
  a_r6_shift_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> shf_cnt == 16'(CHAIN_LEN * (PATTERNS + 2)));
endmodule

bind scan_selftest_ctrl scan_selftest_chk #(
  .CHAIN_LEN(CHAIN_LEN), .PATTERNS(PATTERNS), .SIG_W(SIG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start_i), .busy(busy_o), .done(done_o),
  .pass(pass_o), .sig(sig_o), .shift_evt(chain_shift),
  .capture_evt(in_capt), .run_last_evt(run_last_evt)
);

// File: tb/test_scan_selftest_ctrl.sv
module test_scan_selftest_ctrl;
  // independent bit-level model of a whole run
  function automatic logic [63:0] model(input int L, input int P, input int W,
      input logic [63:0] taps, input logic [63:0] seed, input int SW,
      input logic [63:0] poly);
    logic [63:0] ch, lf, sg, nx, lm, wm, sm;
    logic b, so, msb;
    lm = (64'd1 << L) - 64'd1;
    wm = (64'd1 << W) - 64'd1;
    sm = (64'd1 << SW) - 64'd1;
    ch = '0; lf = '0; sg = '0;
    for (int k = 0; k < L; k++) begin
      b  = seed[6'(L - 1 - k)];
      ch = ((ch << 1) | {63'd0, b}) & lm;
      lf = ((lf << 1) | {63'd0, b}) & wm;
    end
    for (int p = 0; p < P; p++) begin
      for (int k = 0; k < L; k++) begin
        so  = ch[6'(L - 1)];
        b   = lf[6'(W - 1)];
        lf  = ((lf << 1) | {63'd0, ^(lf & taps)}) & wm;
        ch  = ((ch << 1) | {63'd0, b}) & lm;
        msb = sg[6'(SW - 1)];
        sg  = ((sg << 1) | {63'd0, so}) & sm;
        if (msb) sg = sg ^ poly;
      end
      nx = '0;
      for (int i = 0; i < L; i++)
        nx[6'(i)] = ch[6'((i + L - 1) % L)] ^ (ch[6'(i)] & ch[6'((i + 1) % L)]);
      ch = nx;
    end
    for (int k = 0; k < L; k++) begin
      so  = ch[6'(L - 1)];
      ch  = (ch << 1) & lm;
      msb = sg[6'(SW - 1)];
      sg  = ((sg << 1) | {63'd0, so}) & sm;
      if (msb) sg = sg ^ poly;
    end
    return sg;
  endfunction

  localparam logic [63:0] EXP_M = model(8, 6, 8, 64'hB8, 64'hA5, 8, 64'h1D);
  localparam logic [63:0] EXP_A = model(5, 3, 4, 64'h0C, 64'h16, 8, 64'h1D);
  localparam int RUN_M = 8 * (6 + 2) + 6;
  localparam int RUN_A = 5 * (3 + 2) + 3;
  localparam int NVEC = 4;
  localparam int VEC_GAP  [NVEC] = '{0, 3, 1, 5};
  localparam int VEC_SPUR [NVEC] = '{0, 10, 45, RUN_M};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, start_alt = 1'b0;
  logic busy_m, done_m, pass_m, busy_b, done_b, pass_b, busy_a, done_a, pass_a;
  logic [7:0] sig_m, sig_b, sig_a;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  scan_selftest_ctrl #(.GOLDEN(EXP_M[7:0])) i_scan_selftest_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy_m),
    .done_o(done_m), .pass_o(pass_m), .sig_o(sig_m));

  scan_selftest_ctrl #(.GOLDEN(EXP_M[7:0] ^ 8'h01)) i_bad (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy_b),
    .done_o(done_b), .pass_o(pass_b), .sig_o(sig_b));

  scan_selftest_ctrl #(.CHAIN_LEN(5), .PATTERNS(3), .LFSR_W(4), .LFSR_TAPS(4'hC),
    .SEED(5'h16), .GOLDEN(EXP_A[7:0])) i_alt (
    .clk(clk), .rst_n(rst_n), .start_i(start_alt), .busy_o(busy_a),
    .done_o(done_a), .pass_o(pass_a), .sig_o(sig_a));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int gap, input int spur);
    repeat (gap) @(negedge clk);
    start = 1'b1; start_alt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; start_alt = 1'b0;
    chk("R2 busy after start", 64'(busy_m), 64'd1);
    chk("R2 done drops", 64'(done_m), 64'd0);
    for (int c = 1; c <= RUN_M; c++) begin
      if (c == spur) start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (c == RUN_A - 1) chk("R6 alt not yet done", 64'(done_a), 64'd0);
      if (c == RUN_A) begin
        chk("R6 alt done", 64'(done_a), 64'd1);
        chk("R3 alt signature", 64'(sig_a), EXP_A & 64'hFF);
        chk("R8 alt pass", 64'(pass_a), 64'd1);
      end
      if (c == RUN_M - 1) begin
        chk("R6 not yet done", 64'(done_m), 64'd0);
        chk("R9 still busy", 64'(busy_m), 64'd1);
        chk("R8 pass low while busy", 64'(pass_m), 64'd0);
      end
    end
    chk("R6 done on time", 64'(done_m), 64'd1);
    chk("R4 R5 signature", 64'(sig_m), EXP_M & 64'hFF);
    chk("R8 pass", 64'(pass_m), 64'd1);
    chk("R8 wrong golden fails", 64'(pass_b), 64'd0);
    chk("R5 same signature", 64'(sig_b), EXP_M & 64'hFF);
    repeat (3) @(negedge clk);
    chk("R7 done holds", 64'(done_m), 64'd1);
    chk("R7 sig holds", 64'(sig_m), EXP_M & 64'hFF);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", 64'(busy_m), 64'd0);
    chk("R1 done", 64'(done_m), 64'd0);
    chk("R1 pass", 64'(pass_m), 64'd0);
    chk("R1 sig", 64'(sig_m), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NVEC; v++) run_vec(VEC_GAP[v], VEC_SPUR[v]);

    // directed: reset in the middle of a run, then a clean run
    start = 1'b1; start_alt = 1'b1;
    @(negedge clk);
    start = 1'b0; start_alt = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run busy", 64'(busy_m), 64'd0);
    chk("R1 reset mid-run sig", 64'(sig_m), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_vec(2, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule